// File: doc/BRIEF.md
# Interval-gated oblivious cache access unit

This unit sits in front of a small banked, set-associative data cache and hides when and how the cache is used. Requests from the core go into a queue. They reach the storage arrays only at access slots that recur on a fixed public schedule. A wait counter sets the spacing of the slots. At every slot exactly one access is carried out: the oldest queued request, or a dummy access when the queue is empty. Because of this, the activity seen at the memory-side port does not depend on the program.

Every access has the same shape. In a read phase, every way of the addressed set is copied out of every bank into holding registers. In a write phase, every way of that set is written back to every bank. On the memory side a fill strobe fires in every write phase, and its write enable is raised only for a real miss. A dummy access goes through the same motions, but it changes no data, tag or replacement state, and it produces no response.

The address splits into an index, the low `log2(SETS)` bits, and a tag, the remaining upper bits. A line is `BANKS` slices of `BANK_W` bits each, and bank `b` stores bits `[b*BANK_W +: BANK_W]` of every line.

Top module: `obl_cache_gate`

## Requirements
- R1: After reset, `rsp_valid` and `fill_strobe` are low, `req_ready` is high and the queue is empty.
- R2: The unit waits for max(INTERVAL,1) cycles, then spends one read-phase cycle and one write-phase cycle. `fill_strobe` is high exactly in the write phase, so strobes recur every max(INTERVAL,1)+2 cycles whatever the traffic is.
- R3: At the end of the last wait cycle, exactly one request is released, the oldest in the queue. A request accepted in that same cycle waits for the following slot. A released request responds in the second cycle after its release.
- R4: When the queue is empty at a slot, a dummy read of address 0 is performed. It raises no `rsp_valid` and no `fill_we`, and it leaves stored data, tags and replacement order unchanged.
- R5: A read hit returns `rsp_hit`=1 with the stored line in `rsp_data`, and leaves the line unchanged.
- R6: A write hit replaces the line with `req_wdata`, and the response carries `rsp_hit`=1 with the old line.
- R7: A miss responds with `rsp_hit`=0 and `rsp_data`=0. `fill_we` is high in that write phase, with `fill_addr` equal to the request address. A hit strobes `fill_strobe` with `fill_we` low.
- R8: A write miss allocates the first invalid way, or the least recently used way if all ways are valid, and writes the whole line. A read miss allocates nothing.
- R9: Hits and allocations make their way the most recently used. Read misses and dummy accesses leave the order unchanged.
- R10: The queue holds QDEPTH requests in arrival order, and `req_ready` is low while it is full.
- R11: Each bank slice of a line is stored and returned intact, so a line with distinct bytes per bank reads back bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered to the queue |
| req_ready | output | 1 | Queue can accept a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address (index low, tag high) |
| req_wdata | input | BANKS*BANK_W | Full line to write |
| rsp_valid | output | 1 | One-cycle response for a real request |
| rsp_hit | output | 1 | Request hit in the cache |
| rsp_data | output | BANKS*BANK_W | Line before the access on a hit, zero on a miss |
| fill_strobe | output | 1 | Fill-queue enqueue slot, high in every write phase |
| fill_we | output | 1 | Fill-queue write enable, high only for a real miss |
| fill_addr | output | ADDR_W | Address presented with the fill slot |

## Verification
The delicate coincidence is a new request entering the queue in the very cycle the slot releases its occupant. In that cycle a push and a release decision happen together. The bench pushes one request in the second-to-last wait cycle and another in the last wait cycle. The first must respond two cycles after the release. The second must miss the slot, let a dummy pass, and respond one full period later. A queue filled to capacity inside a single wait window then checks that draining happens one request per slot and in order.

// File: rtl/obl_cache_pkg.sv
package obl_cache_pkg;

  typedef enum logic {
    SLOT_WAIT   = 1'b0,
    SLOT_ACCESS = 1'b1
  } slot_state_e;

  // cycles spent waiting before a slot opens
  function automatic int unsigned wait_cycles(input int unsigned interval);
    return (interval == 0) ? 1 : interval;
  endfunction

  // full slot period: wait cycles plus read phase plus write phase
  function automatic int unsigned slot_period(input int unsigned interval);
    return wait_cycles(interval) + 2;
  endfunction

endpackage

// File: rtl/obl_req_fifo.sv
module obl_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (PW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/obl_slot_fsm.sv
module obl_slot_fsm
  import obl_cache_pkg::*;
#(
  parameter int INTERVAL = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  output logic active_o,
  output logic release_o
);
  localparam int TOP = int'(wait_cycles(INTERVAL)) - 1;
  localparam int CW  = $clog2(TOP + 2);

  slot_state_e    state;
  logic [CW-1:0]  cnt;

  assign active_o  = (state == SLOT_ACCESS);
  assign release_o = (state == SLOT_WAIT) && (cnt == CW'(TOP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SLOT_WAIT;
      cnt   <= '0;
    end else begin
      unique case (state)
        SLOT_WAIT: begin
          if (release_o) begin
            state <= SLOT_ACCESS;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SLOT_ACCESS: begin
          if (done_i) state <= SLOT_WAIT;
        end
        default: state <= SLOT_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/obl_banked_store.sv
module obl_banked_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int BANKS  = 4,
  parameter int BANK_W = 8,
  parameter int TAG_W  = 6,
  localparam int IDX_W  = $clog2(SETS),
  localparam int LINE_W = BANKS * BANK_W,
  localparam int AW     = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              real_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [LINE_W-1:0] wdata_i,
  output logic              done_o,
  output logic              hit_o,
  output logic [LINE_W-1:0] rdata_o
);
  logic step;
  logic rd_phase, wr_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) step <= 1'b0;
    else        step <= active_i && !step;
  end

  assign rd_phase = active_i && !step;
  assign wr_phase = active_i && step;
  assign done_o   = wr_phase;

  logic             vld_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [AW-1:0]    age_q [SETS][WAYS];

  logic             h_vld [WAYS];
  logic [TAG_W-1:0] h_tag [WAYS];
  logic [AW-1:0]    h_age [WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        h_vld[w] <= 1'b0;
        h_tag[w] <= '0;
        h_age[w] <= '0;
      end
    end else if (rd_phase) begin
      for (int w = 0; w < WAYS; w++) begin
        h_vld[w] <= vld_q[idx_i][w];
        h_tag[w] <= tag_q[idx_i][w];
        h_age[w] <= age_q[idx_i][w];
      end
    end
  end

  logic          hit, alloc, touch, found;
  logic [AW-1:0] hit_way, victim, tgt;
  logic [AW-1:0] new_age [WAYS];

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (h_vld[w] && h_tag[w] == tag_i) begin
        hit     = 1'b1;
        hit_way = AW'(w);
      end
    end
  end

  always_comb begin
    victim = '0;
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !h_vld[w]) begin
        victim = AW'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (h_age[w] == AW'(WAYS - 1)) victim = AW'(w);
      end
    end
  end

  assign alloc = real_i && wr_i && !hit;
  assign touch = real_i && (hit || alloc);
  assign tgt   = hit ? hit_way : victim;
  assign hit_o = hit;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      new_age[w] = h_age[w];
      if (touch) begin
        if (AW'(w) == tgt)              new_age[w] = '0;
        else if (h_age[w] < h_age[tgt]) new_age[w] = h_age[w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          tag_q[s][w] <= '0;
          age_q[s][w] <= AW'(w);
        end
      end
    end else if (wr_phase) begin
      for (int w = 0; w < WAYS; w++) begin
        vld_q[idx_i][w] <= (alloc && AW'(w) == tgt) ? 1'b1  : h_vld[w];
        tag_q[idx_i][w] <= (alloc && AW'(w) == tgt) ? tag_i : h_tag[w];
        age_q[idx_i][w] <= new_age[w];
      end
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] mem  [SETS][WAYS];
    logic [BANK_W-1:0] hold [WAYS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int w = 0; w < WAYS; w++) hold[w] <= '0;
      end else if (rd_phase) begin
        for (int w = 0; w < WAYS; w++) hold[w] <= mem[idx_i][w];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) mem[s][w] <= '0;
      end else if (wr_phase) begin
        for (int w = 0; w < WAYS; w++)
          mem[idx_i][w] <= (real_i && wr_i && AW'(w) == tgt)
                           ? wdata_i[b*BANK_W +: BANK_W] : hold[w];
      end
    end

    assign rdata_o[b*BANK_W +: BANK_W] = hit ? hold[hit_way] : '0;
  end
endmodule

// File: rtl/obl_cache_gate.sv
module obl_cache_gate #(
  parameter int ADDR_W   = 8,
  parameter int BANKS    = 4,
  parameter int BANK_W   = 8,
  parameter int SETS     = 4,
  parameter int WAYS     = 2,
  parameter int QDEPTH   = 4,
  parameter int INTERVAL = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_wr,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [BANKS*BANK_W-1:0]   req_wdata,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [BANKS*BANK_W-1:0]   rsp_data,
  output logic                      fill_strobe,
  output logic                      fill_we,
  output logic [ADDR_W-1:0]         fill_addr
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LINE_W = BANKS * BANK_W;
  localparam int REQ_W  = 1 + ADDR_W + LINE_W;

  logic              q_empty, q_full;
  logic [REQ_W-1:0]  q_head;
  logic              acc_active, acc_done;
  logic              slot_release, slot_dummy;
  logic              st_hit;
  logic [LINE_W-1:0] st_rdata;

  logic              cur_real, cur_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic [LINE_W-1:0] cur_wdata;

  assign req_ready  = !q_full;
  assign slot_dummy = slot_release && q_empty;

  obl_req_fifo #(.W(REQ_W), .DEPTH(QDEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (req_valid),
    .pop   (slot_release),
    .din   ({req_wr, req_addr, req_wdata}),
    .dout  (q_head),
    .empty (q_empty),
    .full  (q_full)
  );

  obl_slot_fsm #(.INTERVAL(INTERVAL)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (acc_done),
    .active_o  (acc_active),
    .release_o (slot_release)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_real  <= 1'b0;
      cur_wr    <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (slot_release) begin
      cur_real <= !q_empty;
      if (q_empty) begin
        cur_wr    <= 1'b0;
        cur_addr  <= '0;
        cur_wdata <= '0;
      end else begin
        {cur_wr, cur_addr, cur_wdata} <= q_head;
      end
    end
  end

  obl_banked_store #(
    .SETS(SETS), .WAYS(WAYS), .BANKS(BANKS), .BANK_W(BANK_W), .TAG_W(TAG_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (acc_active),
    .real_i   (cur_real),
    .wr_i     (cur_wr),
    .idx_i    (cur_addr[IDX_W-1:0]),
    .tag_i    (cur_addr[ADDR_W-1:IDX_W]),
    .wdata_i  (cur_wdata),
    .done_o   (acc_done),
    .hit_o    (st_hit),
    .rdata_o  (st_rdata)
  );

  assign rsp_valid   = acc_done && cur_real;
  assign rsp_hit     = rsp_valid && st_hit;
  assign rsp_data    = rsp_valid ? st_rdata : '0;
  assign fill_strobe = acc_done;
  assign fill_we     = acc_done && cur_real && !st_hit;
  assign fill_addr   = cur_addr;
endmodule

// File: rtl/obl_cache_gate_chk.sv
module obl_cache_gate_chk
  import obl_cache_pkg::*;
#(
  parameter int INTERVAL = 5,
  parameter int LINE_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [LINE_W-1:0] rsp_data,
  input logic              fill_strobe,
  input logic              fill_we,
  input logic              slot_release,
  input logic              slot_dummy
);
  localparam int PERIOD = int'(slot_period(INTERVAL));

  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (fill_strobe) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 1'b1;
    end
  end

  // R2: strobes are spaced by exactly one slot period
  assert_slot_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_strobe && seen) |-> (gap == 16'(PERIOD - 1)));

  // R2: a release is followed by the read phase, then the write phase
  assert_release_to_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_release |=> (!fill_strobe ##1 fill_strobe));

  // R3: responses appear only in the write phase of a slot
  assert_rsp_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> fill_strobe);

  // R4: a dummy slot produces no response
  assert_dummy_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_dummy |=> ##1 (!rsp_valid && !fill_we));

  // R7: fill write enable only for a real miss
  assert_fill_only_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> (rsp_valid && !rsp_hit));

  // R7: a miss returns an all-zero line
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0));
endmodule

bind obl_cache_gate obl_cache_gate_chk #(.INTERVAL(INTERVAL), .LINE_W(LINE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_data     (rsp_data),
  .fill_strobe  (fill_strobe),
  .fill_we      (fill_we),
  .slot_release (slot_release),
  .slot_dummy   (slot_dummy)
);

// File: tb/tb_obl_cache_gate.sv
module tb_obl_cache_gate;
  localparam int INTERVAL = 5;
  localparam int PERIOD   = ((INTERVAL == 0) ? 1 : INTERVAL) + 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_wr;
  logic        req_ready;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_hit, fill_strobe, fill_we;
  logic [31:0] rsp_data;
  logic [7:0]  fill_addr;

  always #10 clk = ~clk;

  obl_cache_gate #(.INTERVAL(INTERVAL)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .fill_strobe(fill_strobe), .fill_we(fill_we), .fill_addr(fill_addr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic wait_strobe();
    do @(negedge clk); while (!fill_strobe);
  endtask

  task automatic do_req(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        output logic h, output logic [31:0] q,
                        output logic fw, output logic [7:0] fa);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    h = rsp_hit; q = rsp_data; fw = fill_we; fa = fill_addr;
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        hit;
    logic [31:0] data;
  } vec_t;

  // address: index = addr[1:0], tag = addr[7:2]; two ways per set
  localparam vec_t VECS [15] = '{
    '{4'd8,  1'b0, 8'h10, 32'h0,         1'b0, 32'h0},         // R8 read miss, no allocation
    '{4'd7,  1'b1, 8'h10, 32'h1A2B3C4D,  1'b0, 32'h0},         // R7 write miss fills
    '{4'd5,  1'b0, 8'h10, 32'h0,         1'b1, 32'h1A2B3C4D},  // R5
    '{4'd6,  1'b1, 8'h10, 32'h55AA33CC,  1'b1, 32'h1A2B3C4D},  // R6 old data returned
    '{4'd6,  1'b0, 8'h10, 32'h0,         1'b1, 32'h55AA33CC},  // R6 new data stored
    '{4'd8,  1'b1, 8'h20, 32'hC3C30F0F,  1'b0, 32'h0},         // R8 invalid way taken
    '{4'd5,  1'b0, 8'h20, 32'h0,         1'b1, 32'hC3C30F0F},  // R5
    '{4'd9,  1'b0, 8'h10, 32'h0,         1'b1, 32'h55AA33CC},  // R9 0x10 becomes recent
    '{4'd9,  1'b1, 8'h30, 32'hD4E5F607,  1'b0, 32'h0},         // R9 evicts 0x20
    '{4'd9,  1'b0, 8'h20, 32'h0,         1'b0, 32'h0},         // R9 evicted
    '{4'd8,  1'b0, 8'h10, 32'h0,         1'b1, 32'h55AA33CC},  // R8 read miss kept both
    '{4'd5,  1'b0, 8'h30, 32'h0,         1'b1, 32'hD4E5F607},  // R5
    '{4'd7,  1'b0, 8'h11, 32'h0,         1'b0, 32'h0},         // R7 other set
    '{4'd11, 1'b1, 8'h21, 32'h11223344,  1'b0, 32'h0},         // R11
    '{4'd11, 1'b0, 8'h21, 32'h0,         1'b1, 32'h11223344}   // R11 slices intact
  };

  initial begin
    logic        h, fw;
    logic [31:0] q;
    logic [7:0]  fa;
    int          n;
    int          t_prev, t_now;
    req_valid = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R1", "fill_strobe after reset", 64'(fill_strobe), 64'd0);
    chk("R1", "req_ready after reset", 64'(req_ready), 64'd1);

    // R2 and R4: idle strobe spacing, dummies silent
    wait_strobe();
    chk("R4", "idle strobe fill_we", 64'(fill_we), 64'd0);
    n = 0;
    do begin @(negedge clk); n++; end while (!fill_strobe);
    chk("R2", "idle strobe period", 64'(n), 64'(PERIOD));
    chk("R4", "idle rsp_valid", 64'(rsp_valid), 64'd0);

    // vector walk
    for (int i = 0; i < 15; i++) begin
      do_req(VECS[i].wr, VECS[i].addr, VECS[i].wdata, h, q, fw, fa);
      chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d hit", i), 64'(h), 64'(VECS[i].hit));
      chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d data", i), 64'(q), 64'(VECS[i].data));
      chk("R7", $sformatf("vec %0d fill_we", i), 64'(fw), 64'(!VECS[i].hit));
      chk("R7", $sformatf("vec %0d fill_addr", i), 64'(fa), 64'(VECS[i].addr));
    end

    // R4: many dummy slots, then order in set 0 is still 0x10 oldest
    for (int k = 0; k < 5; k++) begin
      wait_strobe();
      chk("R4", "dummy slot rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R4", "dummy slot fill_we", 64'(fill_we), 64'd0);
    end
    do_req(1'b0, 8'h30, 32'h0, h, q, fw, fa);
    chk("R4", "data kept across dummies", 64'(q), 64'h0D4E5F607);
    do_req(1'b1, 8'h40, 32'hE5E5E5E5, h, q, fw, fa);
    chk("R9", "write miss 0x40", 64'(h), 64'd0);
    do_req(1'b0, 8'h10, 32'h0, h, q, fw, fa);
    chk("R9", "0x10 evicted as least recent", 64'(h), 64'd0);
    do_req(1'b0, 8'h30, 32'h0, h, q, fw, fa);
    chk("R9", "0x30 retained", 64'(q), 64'h0D4E5F607);

    // R3: push in second-to-last wait cycle -> served this slot
    wait_strobe();
    repeat (INTERVAL - 1) @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b0; req_addr = 8'h30;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!rsp_valid);
    chk("R3", "push before release latency", 64'(n), 64'd2);
    // R3: push in the release cycle -> waits one full period
    wait_strobe();
    repeat (INTERVAL) @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b0; req_addr = 8'h30;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!rsp_valid);
    chk("R3", "push on release latency", 64'(n), 64'(PERIOD + 1));
    chk("R3", "late push data", 64'(rsp_data), 64'h0D4E5F607);

    // R10: fill queue inside one wait window, drain in order
    wait_strobe();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      req_valid = 1'b1; req_wr = 1'b0;
      req_addr = (k == 0) ? 8'h30 : (k == 1) ? 8'h99 : (k == 2) ? 8'h40 : 8'h77;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "req_ready when full", 64'(req_ready), 64'd0);
    t_prev = 0;
    t_now = 0;
    for (int k = 0; k < 4; k++) begin
      while (!rsp_valid) begin @(negedge clk); t_now++; end
      chk("R10", $sformatf("drain %0d hit", k), 64'(rsp_hit), 64'((k % 2) == 0));
      chk("R10", $sformatf("drain %0d data", k), 64'(rsp_data),
          (k == 0) ? 64'h0D4E5F607 : (k == 2) ? 64'h0E5E5E5E5 : 64'h0);
      if (k > 0) chk("R3", $sformatf("drain %0d spacing", k), 64'(t_now - t_prev), 64'(PERIOD));
      t_prev = t_now;
      @(negedge clk); t_now++;
    end
    report();
  end
endmodule